// File: doc/BRIEF.md
# Shared Word Pointer and Byte Read/Write Sequencer

This block sits between the byte-level bus front end of a two-wire serial memory and its storage. It keeps the single internal word pointer, loads it from the word-address byte that opens a write transaction, and serves read data bytes one at a time as the front end asks for them. It moves the pointer under three rules. Writes step only the in-page bits. Main-array reads step the whole pointer. Reads of the 16-byte identification region step only the low nibble.

The front end reports each new addressed transaction with a one-cycle strobe that carries the direction, the region and the page bits from the device-address byte. It then passes received bytes or read requests. Array data comes from a synchronous RAM read port and identification bytes from a 16-byte ROM read port. Array write bytes go to the page-write block together with their target addresses. Identification bytes are accepted and dropped.

Top module: `wordptr_seq`

## Requirements
- R1: After reset, rd_vld_o and pw_vld_o are low and the pointer is 0, so a read with no word address first returns array byte 0.
- R2: The first byte after a write-direction start loads the pointer. In the array region, the pointer becomes {start_page_i, byte}, with the page bits above bit 7. In the identification region, the pointer becomes {zeros, byte}.
- R3: Each later array write byte appears on pw_vld_o, pw_addr_o and pw_data_o one cycle after it is accepted, carrying the pointer value it was received at.
- R4: On array writes only the low 4 pointer bits advance. The address wraps from offset 15 to offset 0 of the same 16-byte page, and the upper bits do not change.
- R5: Each array read asks the RAM for the byte at the pointer, then advances the full pointer. The pointer wraps from the top address to 0.
- R6: The pointer keeps its value across transactions. A read-direction start with no word address continues at the last accessed address plus one.
- R7: An identification read with pointer bits [7:6] = 2'b10 returns ROM byte pointer[3:0]. Only the low nibble then advances, so offset 15 is followed by offset 0.
- R8: An identification read whose pointer bits [7:6] are not 2'b10 returns 8'hFF.
- R9: Data bytes written to the identification region produce no pw_vld_o and leave the pointer unchanged.
- R10: A read request yields rd_vld_o with the data exactly two cycles after the request cycle. A read request outside a read transaction yields no rd_vld_o.
- R11: Bytes received during a read transaction, or before any start, produce no pw_vld_o and do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | New addressed transaction strobe |
| start_rnw_i | input | 1 | 1 = read transaction, 0 = write transaction |
| start_id_i | input | 1 | 1 = identification region, 0 = main array |
| start_page_i | input | ADDR_W-8 | Page bits taken from the device-address byte |
| wr_vld_i | input | 1 | Received byte strobe |
| wr_byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Request for the next read byte |
| rd_vld_o | output | 1 | Read byte valid |
| rd_data_o | output | 8 | Read byte |
| ram_rd_o | output | 1 | Array RAM read enable |
| ram_addr_o | output | ADDR_W | Array RAM read address |
| ram_data_i | input | 8 | Array RAM data, one cycle after the enable |
| rom_rd_o | output | 1 | Identification ROM read enable |
| rom_addr_o | output | 4 | Identification ROM address |
| rom_data_i | input | 8 | Identification ROM data, one cycle after the enable |
| pw_vld_o | output | 1 | Write byte forwarded to the page-write block |
| pw_addr_o | output | ADDR_W | Target address of the forwarded byte |
| pw_data_o | output | 8 | Forwarded byte |

## Verification
Directed runs cover the following cases:
- Page writes that start at offset 12 and run past offset 15, which separates in-page wrap from a full increment.
- Reads at the top address, which show the full-pointer rollover.
- An 18-byte identification read, which shows the 16-byte window.
- Identification reads with and without the 2'b10 prefix.
- Identification reads after array accesses, which prove the pointer is shared.

Random transactions then mix the four transaction kinds with random pages, word addresses and burst lengths. Misplaced strobes (read requests in write transactions, bytes during reads) are included; they must change neither the outputs nor the pointer.

// File: rtl/wordptr_pkg.sv
package wordptr_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WADDR, SQ_WDATA, SQ_READ} sq_state_t;
  localparam logic [7:0] ID_FILL   = 8'hFF;
  localparam logic [1:0] ID_PREFIX = 2'b10;
endpackage

// File: rtl/wordptr_ptr.sv
module wordptr_ptr #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_low_i,
  input  logic              step_full_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= load_val_i;
    end else if (step_full_i) begin
      ptr_q <= ptr_q + ONE_A;
    end else if (step_low_i) begin
      ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + ONE_P;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/wordptr_rdpath.sv
module wordptr_rdpath
  import wordptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       arr_req_i,
  input  logic       id_req_i,
  input  logic       id_ok_i,
  input  logic [7:0] ram_data_i,
  input  logic [7:0] rom_data_i,
  output logic       rd_vld_o,
  output logic [7:0] rd_data_o
);
  logic pend_q, pend_id_q, pend_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      pend_id_q <= 1'b0;
      pend_ok_q <= 1'b0;
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      pend_q    <= arr_req_i | id_req_i;
      pend_id_q <= id_req_i;
      pend_ok_q <= id_ok_i;
      rd_vld_o  <= pend_q;
      if (pend_q) begin
        if (!pend_id_q)     rd_data_o <= ram_data_i;
        else if (pend_ok_q) rd_data_o <= rom_data_i;
        else                rd_data_o <= ID_FILL;
      end
    end
  end
endmodule

// File: rtl/wordptr_wrfwd.sv
module wordptr_wrfwd #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              pw_vld_o,
  output logic [ADDR_W-1:0] pw_addr_o,
  output logic [7:0]        pw_data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pw_vld_o  <= 1'b0;
      pw_addr_o <= '0;
      pw_data_o <= '0;
    end else begin
      pw_vld_o <= fwd_i;
      if (fwd_i) begin
        pw_addr_o <= addr_i;
        pw_data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/wordptr_seq.sv
module wordptr_seq
  import wordptr_pkg::*;
#(
  parameter int PAGE_BITS = 6,
  parameter int PAGE_W    = 4,
  parameter int ID_W      = 4,
  localparam int ADDR_W   = PAGE_BITS + PAGE_W,
  localparam int HI_W     = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              start_rnw_i,
  input  logic              start_id_i,
  input  logic [HI_W-1:0]   start_page_i,
  input  logic              wr_vld_i,
  input  logic [7:0]        wr_byte_i,
  input  logic              rd_req_i,
  output logic              rd_vld_o,
  output logic [7:0]        rd_data_o,
  output logic              ram_rd_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [7:0]        ram_data_i,
  output logic              rom_rd_o,
  output logic [ID_W-1:0]   rom_addr_o,
  input  logic [7:0]        rom_data_i,
  output logic              pw_vld_o,
  output logic [ADDR_W-1:0] pw_addr_o,
  output logic [7:0]        pw_data_o
);
  sq_state_t         st_q;
  logic              is_id_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] ptr;
  logic              ld, data_byte, fwd, rd_ok, id_ok;
  logic [ADDR_W-1:0] ld_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      is_id_q <= 1'b0;
      hi_q    <= '0;
    end else if (start_i) begin
      st_q    <= start_rnw_i ? SQ_READ : SQ_WADDR;
      is_id_q <= start_id_i;
      hi_q    <= start_page_i;
    end else if (wr_vld_i && st_q == SQ_WADDR) begin
      st_q <= SQ_WDATA;
    end
  end

  always_comb begin
    ld        = wr_vld_i && !start_i && st_q == SQ_WADDR;
    ld_val    = is_id_q ? {{HI_W{1'b0}}, wr_byte_i} : {hi_q, wr_byte_i};
    data_byte = wr_vld_i && !start_i && st_q == SQ_WDATA;
    fwd       = data_byte && !is_id_q;
    rd_ok     = rd_req_i && !start_i && st_q == SQ_READ;
    ram_rd_o  = rd_ok && !is_id_q;
    rom_rd_o  = rd_ok && is_id_q;
    id_ok     = ptr[7:6] == ID_PREFIX;
  end

  assign ram_addr_o = ptr;
  assign rom_addr_o = ptr[ID_W-1:0];

  wordptr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ptr_i (
    .clk(clk), .rst(rst), .load_i(ld), .load_val_i(ld_val),
    .step_low_i(fwd | rom_rd_o), .step_full_i(ram_rd_o), .ptr_o(ptr)
  );

  wordptr_rdpath rd_i (
    .clk(clk), .rst(rst), .arr_req_i(ram_rd_o), .id_req_i(rom_rd_o),
    .id_ok_i(id_ok), .ram_data_i(ram_data_i), .rom_data_i(rom_data_i),
    .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o)
  );

  wordptr_wrfwd #(.ADDR_W(ADDR_W)) wr_i (
    .clk(clk), .rst(rst), .fwd_i(fwd), .addr_i(ptr), .data_i(wr_byte_i),
    .pw_vld_o(pw_vld_o), .pw_addr_o(pw_addr_o), .pw_data_o(pw_data_o)
  );
endmodule

// File: rtl/wordptr_seq_chk.sv
module wordptr_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_vld_i,
  input logic [7:0]        wr_byte_i,
  input logic              rd_req_i,
  input logic              rd_vld_o,
  input logic              ram_rd_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              pw_vld_o,
  input logic [ADDR_W-1:0] pw_addr_o,
  input logic [7:0]        pw_data_o
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_vld_o && !pw_vld_o));

  p_fwd_source_r3: assert property (@(posedge clk) disable iff (rst)
    pw_vld_o |-> ($past(wr_vld_i) && pw_data_o == $past(wr_byte_i)));

  p_page_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    (pw_vld_o && $past(pw_vld_o)) |->
      (pw_addr_o[ADDR_W-1:PAGE_W] == $past(pw_addr_o[ADDR_W-1:PAGE_W]) &&
       pw_addr_o[PAGE_W-1:0] == PAGE_W'($past(pw_addr_o[PAGE_W-1:0]) + 1'b1)));

  p_full_step_r5: assert property (@(posedge clk) disable iff (rst)
    $past(ram_rd_o) |-> (ram_addr_o == ADDR_W'($past(ram_addr_o) + 1'b1)));

  p_read_latency_r10: assert property (@(posedge clk) disable iff (rst)
    rd_vld_o |-> $past(rd_req_i, 2));
endmodule

bind wordptr_seq wordptr_seq_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rst(rst), .wr_vld_i(wr_vld_i), .wr_byte_i(wr_byte_i),
  .rd_req_i(rd_req_i), .rd_vld_o(rd_vld_o), .ram_rd_o(ram_rd_o),
  .ram_addr_o(ram_addr_o), .pw_vld_o(pw_vld_o), .pw_addr_o(pw_addr_o),
  .pw_data_o(pw_data_o)
);

// File: tb/wordptr_seq_tb_top.sv
`timescale 1ns/1ps
module wordptr_seq_tb_top;
  localparam int PAGE_BITS = 6;
  localparam int ADDR_W    = PAGE_BITS + 4;
  localparam int HI_W      = ADDR_W - 8;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, start_rnw_i = 0, start_id_i = 0;
  logic [HI_W-1:0] start_page_i = '0;
  logic wr_vld_i = 0, rd_req_i = 0;
  logic [7:0] wr_byte_i = '0;
  logic rd_vld_o, ram_rd_o, rom_rd_o, pw_vld_o;
  logic [7:0] rd_data_o, pw_data_o, ram_q, rom_q;
  logic [ADDR_W-1:0] ram_addr_o, pw_addr_o;
  logic [3:0] rom_addr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [ADDR_W-1:0] mptr = '0;
  int bmode = 0;
  bit bid = 0;
  logic [HI_W-1:0] bpage = '0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_f(logic [ADDR_W-1:0] a);
    return 8'(a * 13 + (a >> 8) * 7 + 1);
  endfunction
  function automatic logic [7:0] rom_f(logic [3:0] i);
    return 8'(i * 8'h1D) ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (ram_rd_o) ram_q <= mem_f(ram_addr_o);
  always_ff @(posedge clk) if (rom_rd_o) rom_q <= rom_f(rom_addr_o);

  wordptr_seq #(.PAGE_BITS(PAGE_BITS)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_rnw_i(start_rnw_i),
    .start_id_i(start_id_i), .start_page_i(start_page_i), .wr_vld_i(wr_vld_i),
    .wr_byte_i(wr_byte_i), .rd_req_i(rd_req_i), .rd_vld_o(rd_vld_o),
    .rd_data_o(rd_data_o), .ram_rd_o(ram_rd_o), .ram_addr_o(ram_addr_o),
    .ram_data_i(ram_q), .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o),
    .rom_data_i(rom_q), .pw_vld_o(pw_vld_o), .pw_addr_o(pw_addr_o),
    .pw_data_o(pw_data_o)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic start_txn(bit rnw, bit id, logic [HI_W-1:0] pg);
    start_i = 1; start_rnw_i = rnw; start_id_i = id; start_page_i = pg;
    @(negedge clk);
    start_i = 0;
    bmode = rnw ? 3 : 1; bid = id; bpage = pg;
  endtask

  task automatic send_byte(logic [7:0] b);
    wr_vld_i = 1; wr_byte_i = b;
    @(negedge clk);
    wr_vld_i = 0;
    if (bmode == 1) begin
      mptr = bid ? {{HI_W{1'b0}}, b} : {bpage, b};
      bmode = 2;
      check("R2 no fwd on word address", 16'(pw_vld_o), 16'd0);
    end else if (bmode == 2 && !bid) begin
      check("R3 fwd valid", 16'(pw_vld_o), 16'd1);
      check("R3 R4 fwd address", 16'(pw_addr_o), 16'(mptr));
      check("R3 fwd data", 16'(pw_data_o), 16'(b));
      mptr[3:0] = mptr[3:0] + 4'd1;
    end else if (bmode == 2) begin
      check("R9 id write not forwarded", 16'(pw_vld_o), 16'd0);
    end else begin
      check("R11 stray byte not forwarded", 16'(pw_vld_o), 16'd0);
    end
  endtask

  task automatic read_byte();
    logic [7:0] exp;
    rd_req_i = 1;
    @(negedge clk);
    rd_req_i = 0;
    @(negedge clk);
    if (bmode == 3) begin
      if (!bid) begin
        exp = mem_f(mptr);
        mptr = mptr + 1'b1;
        check("R10 array read valid", 16'(rd_vld_o), 16'd1);
        check("R5 R6 array read data", 16'(rd_data_o), 16'(exp));
      end else begin
        exp = (mptr[7:6] == 2'b10) ? rom_f(mptr[3:0]) : 8'hFF;
        mptr[3:0] = mptr[3:0] + 4'd1;
        check("R10 id read valid", 16'(rd_vld_o), 16'd1);
        check("R7 R8 id read data", 16'(rd_data_o), 16'(exp));
      end
    end else begin
      check("R10 stray request ignored", 16'(rd_vld_o), 16'd0);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 rd_vld after reset", 16'(rd_vld_o), 16'd0);
    check("R1 pw_vld after reset", 16'(pw_vld_o), 16'd0);
    // R1: bare read from reset pointer 0, then R5 increment
    start_txn(1, 0, '0);
    check("R1 pointer zero", 16'(ram_addr_o), 16'd0);
    read_byte(); read_byte();
    // R4: page write wrapping inside page 3
    start_txn(0, 0, 2'd3);
    send_byte(8'hFC);
    for (int i = 0; i < 6; i++) send_byte(8'(8'h30 + i));
    // R6: bare read continues at last + 1
    start_txn(1, 0, '0);
    read_byte();
    // R5: random read at top address, rollover to 0
    start_txn(0, 0, 2'd3); send_byte(8'hFF);
    start_txn(1, 0, '0);
    read_byte(); read_byte();
    // R7: identification read across the 16-byte window
    start_txn(0, 1, '0); send_byte(8'h80);
    start_txn(1, 1, '0);
    for (int i = 0; i < 18; i++) read_byte();
    // R8: no prefix
    start_txn(0, 1, '0); send_byte(8'h05);
    start_txn(1, 1, '0); read_byte();
    // R9: id write bytes discarded, pointer unchanged
    start_txn(0, 1, '0); send_byte(8'h83); send_byte(8'hAA); send_byte(8'h55);
    start_txn(1, 1, '0); read_byte();
    // R10 / R11: stray strobes
    start_txn(0, 0, 2'd1); send_byte(8'h20);
    read_byte();
    start_txn(1, 0, '0);
    send_byte(8'h99);
    read_byte();
    // R2 / R7: shared pointer, array address then bare id read
    start_txn(0, 0, 2'd0); send_byte(8'h85);
    start_txn(1, 1, '0); read_byte(); read_byte();

    void'($urandom(32'hC0FFEE));
    for (int t = 0; t < 300; t++) begin
      int op, n;
      op = $urandom_range(0, 5);
      n  = $urandom_range(0, 20);
      case (op)
        0: begin
          start_txn(0, 0, HI_W'($urandom));
          send_byte(8'($urandom));
          for (int k = 0; k < n; k++) send_byte(8'($urandom));
        end
        1: begin
          start_txn(0, 1, '0);
          send_byte(($urandom_range(0, 1) == 1) ? 8'(8'h80 | $urandom_range(0, 15)) : 8'($urandom));
          for (int k = 0; k < n % 3; k++) send_byte(8'($urandom));
        end
        2: begin start_txn(1, 0, '0); for (int k = 0; k <= n; k++) read_byte(); end
        3: begin start_txn(1, 1, '0); for (int k = 0; k <= n; k++) read_byte(); end
        4: begin start_txn(0, 0, HI_W'($urandom)); send_byte(8'($urandom)); read_byte(); end
        default: begin start_txn(1, ($urandom_range(0, 1) == 1), '0); send_byte(8'($urandom)); read_byte(); end
      endcase
    end
    summary();
  end
endmodule